// File: doc/BRIEF.md
# TLB Miss Fault Capture

This block records the state a handler needs after an address translation miss on a load or a store. When the miss strobe is raised, it does several things on the next clock edge:

- latches the faulting virtual address;
- merges that address into the page-table pointer register and the translation high-entry register;
- encodes the miss kind into the cause register;
- saves the return address, but only if the exception level bit was clear;
- sets the exception level bit.

In the following cycle it presents the handler target address, for one cycle only. The target depends on the interrupt enable bit.

Software reaches the registers through a small port: one write enable, a 3-bit select, write data, and a combinational read-data output. The lookup itself and the refill handler sit outside the block.

Top module: `tlbf_capture`

## Requirements
- R1: After reset every register reads as zero, `vec_valid` is low, and `status_exl` and `status_ie` are low.
- R2: After a miss, the fault address register (select 0) holds the full 32-bit `miss_vaddr`.
- R3: After a miss, the page-table pointer register (select 1) holds `miss_vaddr[31:13]` in bits 22:4 and keeps its old bits 31:23 and 3:0. A software write to select 1 changes only bits 31:23.
- R4: After a miss, the translation high-entry register (select 2) holds `miss_vaddr[31:13]` in bits 31:13 and keeps its old bits 12:0. A software write to select 2 replaces all 32 bits.
- R5: After a miss, the cause register (select 3) holds code 2 for a load (`miss_store`=0) or code 3 for a store in bits 6:2, and all other bits are zero.
- R6: The return address register (select 4) takes `miss_pc - 4` on a miss that finds the exception level bit clear. It is left unchanged on a miss that finds the bit set.
- R7: The cycle after a miss, `vec_valid` is high for exactly one cycle. At the same time `vec_pc` is 0x80000180 if the interrupt enable bit was 1 at the miss, and 0x80000000 if it was 0.
- R8: Every miss sets the exception level bit to 1 and leaves the interrupt enable bit unchanged.
- R9: A register-port write in the same cycle as a miss is dropped entirely.
- R10: The status word (select 5) has interrupt enable in bit 0 and exception level in bit 1. A write to it takes effect at the next edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Translation miss strobe, one cycle |
| miss_store | input | 1 | 1 for a store miss, 0 for a load miss |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_pc | input | 32 | Program counter at the miss |
| reg_we | input | 1 | Register port write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| vec_valid | output | 1 | Handler target valid pulse |
| vec_pc | output | 32 | Handler target address |
| status_exl | output | 1 | Exception level bit |
| status_ie | output | 1 | Interrupt enable bit |

## Verification
Register updates from a miss or a write appear on the read port one edge after the stimulus. The handler target pulse is also due exactly one edge later. The driver pushes each expected target into a queue at the moment it presents the miss. The monitor samples on falling edges, so it sees the pulse in the first half-cycle after the capturing edge and flags any pulse without a queued item. Register reads are made half a clock after the update edge, with the select settled, and compared against a bench model updated from the requirements.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned PAGE_SHIFT = 13;
  localparam int unsigned CTX_HI_LSB = 23;
  localparam int unsigned CTX_LO_W   = 4;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned CODE_LSB   = 2;

  localparam logic [CODE_W-1:0] EXC_TLB_LOAD  = 5'd2;
  localparam logic [CODE_W-1:0] EXC_TLB_STORE = 5'd3;

  localparam logic [XLEN-1:0] VEC_BASE    = 32'h8000_0000;
  localparam logic [XLEN-1:0] VEC_GEN_OFS = 32'h0000_0180;

  typedef enum logic [SEL_W-1:0] {
    SEL_BADV   = 3'd0,
    SEL_CTX    = 3'd1,
    SEL_EHI    = 3'd2,
    SEL_CAUSE  = 3'd3,
    SEL_EPC    = 3'd4,
    SEL_STATUS = 3'd5
  } csr_sel_e;
endpackage

// File: rtl/tlbf_field_merge.sv
module tlbf_field_merge
  import tlbf_pkg::*;
#(
  parameter int unsigned W      = XLEN,
  parameter int unsigned PSHIFT = PAGE_SHIFT,
  parameter int unsigned HI_LSB = CTX_HI_LSB,
  parameter int unsigned LO_W   = CTX_LO_W
) (
  input  logic [W-1:0] fault_addr,
  input  logic [W-1:0] ctx_cur,
  input  logic [W-1:0] ehi_cur,
  output logic [W-1:0] ctx_fault,
  output logic [W-1:0] ehi_fault
);
  localparam int unsigned VPN_W = W - PSHIFT;

  logic [VPN_W-1:0] vpn;

  always_comb begin
    vpn       = fault_addr[W-1:PSHIFT];
    // page-table pointer: keep base above and low bits, drop page number between
    ctx_fault = {ctx_cur[W-1:HI_LSB], vpn, ctx_cur[LO_W-1:0]};
    // high entry: page number on top, address-space id kept below
    ehi_fault = {vpn, ehi_cur[PSHIFT-1:0]};
  end
endmodule

// File: rtl/tlbf_fault_decode.sv
module tlbf_fault_decode
  import tlbf_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         is_store,
  input  logic         ie,
  output logic [W-1:0] cause_fault,
  output logic [W-1:0] vec_target
);
  always_comb begin
    cause_fault = '0;
    cause_fault[CODE_LSB +: CODE_W] = is_store ? EXC_TLB_STORE : EXC_TLB_LOAD;
    vec_target  = ie ? (VEC_BASE + VEC_GEN_OFS) : VEC_BASE;
  end
endmodule

// File: rtl/tlbf_csr_file.sv
module tlbf_csr_file
  import tlbf_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_fire,
  input  logic [W-1:0]     fault_addr,
  input  logic [W-1:0]     fault_pc,
  input  logic [W-1:0]     ctx_fault,
  input  logic [W-1:0]     ehi_fault,
  input  logic [W-1:0]     cause_fault,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     badv_q,
  output logic [W-1:0]     ctx_q,
  output logic [W-1:0]     ehi_q,
  output logic [W-1:0]     cause_q,
  output logic [W-1:0]     epc_q,
  output logic             ie_q,
  output logic             exl_q
);
  localparam logic [W-1:0] PC_STEP = W'(4);

  logic [W-1:0] badv_d, ctx_d, ehi_d, cause_d, epc_d;
  logic         ie_d, exl_d;
  logic         sw_wr;

  always_comb begin
    // a capture in the same cycle wins over any port write
    sw_wr   = wr_en && !miss_fire;
    badv_d  = badv_q;
    ctx_d   = ctx_q;
    ehi_d   = ehi_q;
    cause_d = cause_q;
    epc_d   = epc_q;
    ie_d    = ie_q;
    exl_d   = exl_q;
    if (miss_fire) begin
      badv_d  = fault_addr;
      ctx_d   = ctx_fault;
      ehi_d   = ehi_fault;
      cause_d = cause_fault;
      if (!exl_q) epc_d = fault_pc - PC_STEP;
      exl_d   = 1'b1;
    end else if (sw_wr) begin
      unique case (csr_sel_e'(wr_sel))
        SEL_CTX:    ctx_d[W-1:CTX_HI_LSB] = wr_data[W-1:CTX_HI_LSB];
        SEL_EHI:    ehi_d = wr_data;
        SEL_STATUS: begin
          ie_d  = wr_data[0];
          exl_d = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badv_q  <= '0;
      ctx_q   <= '0;
      ehi_q   <= '0;
      cause_q <= '0;
      epc_q   <= '0;
      ie_q    <= 1'b0;
      exl_q   <= 1'b0;
    end else begin
      badv_q  <= badv_d;
      ctx_q   <= ctx_d;
      ehi_q   <= ehi_d;
      cause_q <= cause_d;
      epc_q   <= epc_d;
      ie_q    <= ie_d;
      exl_q   <= exl_d;
    end
  end
endmodule

// File: rtl/tlbf_capture.sv
module tlbf_capture
  import tlbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic              miss_store,
  input  logic [XLEN-1:0]   miss_vaddr,
  input  logic [XLEN-1:0]   miss_pc,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  output logic              vec_valid,
  output logic [XLEN-1:0]   vec_pc,
  output logic              status_exl,
  output logic              status_ie
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [XLEN-1:0] badv_q, ctx_q, ehi_q, cause_q, epc_q;
  logic            ie_q, exl_q;
  logic [XLEN-1:0] ctx_fault, ehi_fault, cause_fault, vec_target;

  tlbf_field_merge u_merge (
    .fault_addr (miss_vaddr),
    .ctx_cur    (ctx_q),
    .ehi_cur    (ehi_q),
    .ctx_fault  (ctx_fault),
    .ehi_fault  (ehi_fault)
  );

  tlbf_fault_decode u_decode (
    .is_store    (miss_store),
    .ie          (ie_q),
    .cause_fault (cause_fault),
    .vec_target  (vec_target)
  );

  tlbf_csr_file u_csr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .miss_fire   (miss_valid),
    .fault_addr  (miss_vaddr),
    .fault_pc    (miss_pc),
    .ctx_fault   (ctx_fault),
    .ehi_fault   (ehi_fault),
    .cause_fault (cause_fault),
    .wr_en       (reg_we),
    .wr_sel      (reg_sel),
    .wr_data     (reg_wdata),
    .badv_q      (badv_q),
    .ctx_q       (ctx_q),
    .ehi_q       (ehi_q),
    .cause_q     (cause_q),
    .epc_q       (epc_q),
    .ie_q        (ie_q),
    .exl_q       (exl_q)
  );

  // handler target register
  logic            vec_valid_q, vec_valid_d;
  logic [XLEN-1:0] vec_pc_q;
  logic            vec_pc_en;

  always_comb begin
    vec_valid_d = miss_valid;
    vec_pc_en   = miss_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_valid_q <= 1'b0;
      vec_pc_q    <= '0;
    end else begin
      vec_valid_q <= vec_valid_d;
      if (vec_pc_en) vec_pc_q <= vec_target;
    end
  end

  // read port
  always_comb begin
    unique case (csr_sel_e'(reg_sel))
      SEL_BADV:   reg_rdata = badv_q;
      SEL_CTX:    reg_rdata = ctx_q;
      SEL_EHI:    reg_rdata = ehi_q;
      SEL_CAUSE:  reg_rdata = cause_q;
      SEL_EPC:    reg_rdata = epc_q;
      SEL_STATUS: reg_rdata = {{(XLEN-2){1'b0}}, exl_q, ie_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign vec_valid  = vec_valid_q;
  assign vec_pc     = vec_pc_q;
  assign status_exl = exl_q;
  assign status_ie  = ie_q;
endmodule

// File: rtl/tlbf_capture_chk.sv
module tlbf_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_valid,
  input logic        miss_store,
  input logic [31:0] miss_vaddr,
  input logic [31:0] miss_pc,
  input logic        reg_we,
  input logic        vec_valid,
  input logic [31:0] vec_pc,
  input logic [31:0] badv_q,
  input logic [31:0] ctx_q,
  input logic [31:0] ehi_q,
  input logic [31:0] cause_q,
  input logic [31:0] epc_q,
  input logic        ie_q,
  input logic        exl_q
);
  a_r2_badv_load: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> badv_q == $past(miss_vaddr));

  a_r3_ctx_merge: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (ctx_q[31:23] == $past(ctx_q[31:23])) && (ctx_q[3:0] == $past(ctx_q[3:0]))
                   && (ctx_q[22:4] == $past(miss_vaddr[31:13])));

  a_r4_ehi_merge: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (ehi_q[31:13] == $past(miss_vaddr[31:13])) && (ehi_q[12:0] == $past(ehi_q[12:0])));

  a_r5_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> cause_q == ($past(miss_store) ? 32'd12 : 32'd8));

  a_r6_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && exl_q) |=> $stable(epc_q));

  a_r6_epc_save: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !exl_q) |=> epc_q == $past(miss_pc) - 32'd4);

  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> vec_valid && (vec_pc == ($past(ie_q) ? 32'h8000_0180 : 32'h8000_0000)));

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !vec_valid);

  a_r8_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> exl_q && (ie_q == $past(ie_q)));

  a_r9_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && reg_we) |=> ctx_q[31:23] == $past(ctx_q[31:23]));
endmodule

bind tlbf_capture tlbf_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .miss_valid (miss_valid),
  .miss_store (miss_store),
  .miss_vaddr (miss_vaddr),
  .miss_pc    (miss_pc),
  .reg_we     (reg_we),
  .vec_valid  (vec_valid),
  .vec_pc     (vec_pc),
  .badv_q     (badv_q),
  .ctx_q      (ctx_q),
  .ehi_q      (ehi_q),
  .cause_q    (cause_q),
  .epc_q      (epc_q),
  .ie_q       (ie_q),
  .exl_q      (exl_q)
);

// File: tb/tlbf_capture_bench.sv
module tlbf_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_store = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic [31:0] miss_pc = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        vec_valid;
  logic [31:0] vec_pc;
  logic        status_exl, status_ie;

  always #2 clk = ~clk;

  tlbf_capture u_tlbf_capture (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_store(miss_store),
    .miss_vaddr(miss_vaddr), .miss_pc(miss_pc), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_pc(vec_pc),
    .status_exl(status_exl), .status_ie(status_ie)
  );

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  // bench model of the register file
  logic [31:0] m_badv = '0, m_ctx = '0, m_ehi = '0, m_cause = '0, m_epc = '0;
  logic        m_ie = 1'b0, m_exl = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops an expected target for every pulse
  always @(negedge clk) begin
    if (running) begin
      if (vec_valid) begin
        if (exp_q.size() == 0) check("R7 unexpected pulse", 32'd1, 32'd0);
        else check("R7 vector", vec_pc, exp_q.pop_front());
      end
    end
  end

  task automatic read_check(input logic [2:0] sel, input logic [31:0] exp, input string req);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic check_all();
    read_check(3'd0, m_badv, "R2 fault address");
    read_check(3'd1, m_ctx, "R3 page-table pointer");
    read_check(3'd2, m_ehi, "R4 high entry");
    read_check(3'd3, m_cause, "R5 cause");
    read_check(3'd4, m_epc, "R6 return address");
    read_check(3'd5, {30'd0, m_exl, m_ie}, "R8 R10 status");
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd1: m_ctx = {data[31:23], m_ctx[22:0]};
      3'd2: m_ehi = data;
      3'd5: begin m_ie = data[0]; m_exl = data[1]; end
      default: ;
    endcase
  endtask

  // driver: present a miss, optionally with a competing write
  task automatic do_miss(input logic [31:0] addr, input logic st, input logic [31:0] pc,
                         input logic with_wr, input logic [2:0] wsel, input logic [31:0] wdata);
    @(negedge clk);
    miss_valid = 1'b1; miss_store = st; miss_vaddr = addr; miss_pc = pc;
    reg_we = with_wr; reg_sel = wsel; reg_wdata = wdata;
    exp_q.push_back(m_ie ? 32'h8000_0180 : 32'h8000_0000);
    m_badv  = addr;
    m_ctx   = (m_ctx & 32'hFF80_000F) | ((addr >> 9) & 32'h007F_FFF0);
    m_ehi   = (addr & 32'hFFFF_E000) | (m_ehi & 32'h0000_1FFF);
    m_cause = st ? 32'd12 : 32'd8;
    if (!m_exl) m_epc = pc - 32'd4;
    m_exl   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    #100000;
    check("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    // R1: reset state
    check("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
    check_all();
    // R10: enable interrupts
    sw_write(3'd5, 32'h0000_0001);
    read_check(3'd5, 32'd1, "R10 status write");
    // load miss, EXL clear, IE set
    do_miss(32'h1234_5678, 1'b0, 32'h0000_1000, 1'b0, 3'd0, 32'd0);
    check_all();
    // store miss with EXL already set: EPC kept
    do_miss(32'hCAFE_F00D, 1'b1, 32'h0000_2000, 1'b0, 3'd0, 32'd0);
    check_all();
    // software writes: context upper bits only, full high entry
    sw_write(3'd1, 32'hFFFF_FFFF);
    read_check(3'd1, m_ctx, "R3 software write");
    sw_write(3'd2, 32'h0000_1ABC);
    read_check(3'd2, 32'h0000_1ABC, "R4 software write");
    sw_write(3'd5, 32'h0000_0000);
    check("R10 status cleared", {30'd0, status_exl, status_ie}, 32'd0);
    // IE clear selects the base vector
    do_miss(32'h8765_4321, 1'b0, 32'h0040_0010, 1'b0, 3'd0, 32'd0);
    check_all();
    // R9: competing high-entry write dropped
    do_miss(32'h0000_4000, 1'b1, 32'h0000_3000, 1'b1, 3'd2, 32'hDEAD_BEEF);
    check_all();
    // R9: competing status and context writes dropped
    do_miss(32'hFFFF_FFFF, 1'b0, 32'h0000_3004, 1'b1, 3'd5, 32'h0000_0001);
    check("R9 status write dropped", {30'd0, status_exl, status_ie}, 32'd2);
    do_miss(32'h0000_0000, 1'b0, 32'h0000_3008, 1'b1, 3'd1, 32'h0000_0000);
    check_all();
    // R6: return address wraps when pc is zero
    sw_write(3'd5, 32'h0000_0001);
    do_miss(32'hA5A5_A5A5, 1'b1, 32'h0000_0000, 1'b0, 3'd0, 32'd0);
    check_all();
    // R7: pulse lasts one cycle and every target was seen
    repeat (2) @(negedge clk);
    check("R7 pulse ended", {31'd0, vec_valid}, 32'd0);
    check("R7 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule